// File: doc/BRIEF.md
# Gated Square Wave Generator

This block is a down-counter that turns a 16-bit count N into a periodic square wave on `out`. The wave has a period of N clock cycles and repeats for as long as the block runs. The counter drops by two on every enabled clock. Each time it runs out, the output changes level and the counter reloads. For odd N the loaded value is N-1. On the falling side one extra clock is inserted before the output drops, so the high half is one clock longer than the low half.

A level input `gate` controls the block. While `gate` is high the counter runs. While `gate` is low the counter holds and the output is forced high without waiting for a clock. A rising edge of `gate` restarts the current half-cycle from the start. Software writes a count through a single-cycle strobe. The first count after reset, or a count followed by a `gate` rising edge, is loaded on the next clock. A count written while the wave is running waits until the current half-cycle ends.

Top module: `sqw_gen`

## Requirements
- R1: After reset `out` is high, and it stays high while no legal count has been written, even with `gate` high.
- R2: A count written with `gate` high is loaded on the clock edge after the one that samples `wr_en`. Counting from the sampling edge, `out` first falls after 1 + ceil(N/2) clocks.
- R3: For an even N, `out` is high for N/2 clocks and low for N/2 clocks, repeating.
- R4: For an odd N, `out` is high for (N+1)/2 clocks and low for (N-1)/2 clocks, repeating.
- R5: A written count value of 0 stands for 65536, which gives halves of 32768 clocks.
- R6: A write of the value 1 is discarded. It neither starts an idle block nor changes the wave of a running one.
- R7: While `gate` is low, `out` is high in the same cycle, with no clock edge needed, and the counter holds its value.
- R8: The first clock edge that samples `gate` high after it was low reloads the count with `out` high. `out` then falls after ceil(N/2) further edges.
- R9: A count written while the wave is running does not shorten or lengthen the current half-cycle. It is used from the next reload onward.
- R10: If a rising edge of `gate` follows a running-time write, the new count is loaded on that trigger edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| gate | input | 1 | Run enable; a rising edge restarts the half-cycle |
| wr_en | input | 1 | One-cycle strobe that writes `wr_count` |
| wr_count | input | 16 | Count N; 0 means 65536, 1 is discarded |
| out | output | 1 | Square wave output |

## Verification
Any fault in the counter or in the phase state shows up at `out` as a wrong high or low width. A counter value that skips the expiry point, for example an odd value, leaves `out` stuck, so the next edge never comes and the timeout in each wait reports it. Wrong handling of pending counts shows within one half-cycle of the write, either as a current half of the wrong length or as a trigger that restarts with the old count. The gate forcing is checked in the same cycle as the `gate` change, without waiting for a clock edge.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  // Action the counter takes on an enabled clock while running
  typedef enum logic [1:0] {
    STEP_DEC  = 2'd0,  // keep counting down by two
    STEP_FLIP = 2'd1,  // half expired: change level and reload
    STEP_HOLD = 2'd2,  // odd count, high half expired: one extra clock
    STEP_FALL = 2'd3   // extra clock done: drive low and reload
  } step_t;
endpackage

// File: rtl/sqw_count_reg.sv
module sqw_count_reg #(
  parameter int CNT_W = 16,
  localparam int CW = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CNT_W-1:0] wr_count,
  input  logic          take,
  output logic          wr_ok,
  output logic [CW-1:0] next_n,
  output logic          act_odd
);
  localparam logic [CW-1:0] FULL_N = {1'b1, {CNT_W{1'b0}}};

  logic [CW-1:0] act_n;
  logic [CW-1:0] pend_n;
  logic          pend_vld;
  logic [CW-1:0] wr_ext;

  assign wr_ok  = wr_en && (wr_count != CNT_W'(1));
  assign wr_ext = (wr_count == '0) ? FULL_N : {1'b0, wr_count};
  assign next_n = pend_vld ? pend_n : act_n;
  assign act_odd = act_n[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_n    <= '0;
      pend_n   <= '0;
      pend_vld <= 1'b0;
    end else begin
      if (take) begin
        act_n    <= next_n;
        pend_vld <= 1'b0;
      end
      if (wr_ok) begin
        pend_n   <= wr_ext;
        pend_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sqw_gate_edge.sv
module sqw_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic rise
);
  logic gate_d;

  always_ff @(posedge clk) begin
    if (rst) gate_d <= 1'b0;
    else     gate_d <= gate;
  end

  assign rise = gate & ~gate_d;
endmodule

// File: rtl/sqw_half_cnt.sv
module sqw_half_cnt #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          to_zero,
  input  logic          dec,
  input  logic          odd,
  input  logic          hi_phase,
  output logic [CW-1:0] cnt,
  output sqw_pkg::step_t step
);
  import sqw_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (load)    cnt <= load_val & ~CW'(1);
    else if (to_zero) cnt <= '0;
    else if (dec)     cnt <= cnt - CW'(2);
  end

  always_comb begin
    if (cnt == '0)                         step = STEP_FALL;
    else if (cnt == CW'(2) && odd && hi_phase) step = STEP_HOLD;
    else if (cnt == CW'(2))                step = STEP_FLIP;
    else                                   step = STEP_DEC;
  end
endmodule

// File: rtl/sqw_gen.sv
module sqw_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_count,
  output logic             out
);
  import sqw_pkg::*;
  localparam int CW = CNT_W + 1;

  logic          wr_ok, act_odd, rise, take;
  logic [CW-1:0] next_n, cnt_q;
  step_t         step;
  logic          out_q, armed, need_load;
  logic          do_load, run, cnt_zero, cnt_dec;

  sqw_count_reg #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_count(wr_count), .take(take),
    .wr_ok(wr_ok), .next_n(next_n), .act_odd(act_odd)
  );

  sqw_gate_edge u_edge (.clk(clk), .rst(rst), .gate(gate), .rise(rise));

  sqw_half_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(take), .load_val(next_n), .to_zero(cnt_zero),
    .dec(cnt_dec), .odd(act_odd), .hi_phase(out_q), .cnt(cnt_q), .step(step)
  );

  assign do_load  = gate & (need_load | (rise & armed));
  assign run      = gate & armed & ~do_load;
  assign take     = do_load | (run & ((step == STEP_FLIP) || (step == STEP_FALL)));
  assign cnt_zero = run & (step == STEP_HOLD);
  assign cnt_dec  = run & (step == STEP_DEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= 1'b1;
      armed     <= 1'b0;
      need_load <= 1'b0;
    end else begin
      if (do_load) begin
        need_load <= 1'b0;
        armed     <= 1'b1;
      end
      if (wr_ok && !armed) need_load <= 1'b1;
      if (!gate || do_load)                 out_q <= 1'b1;
      else if (run && step == STEP_FLIP)    out_q <= ~out_q;
      else if (run && step == STEP_FALL)    out_q <= 1'b0;
    end
  end

  // gate low overrides the registered level without a clock
  assign out = out_q | ~gate;
endmodule

// File: rtl/sqw_gen_chk.sv
module sqw_gen_chk #(
  parameter int CNT_W = 16,
  localparam int CW = CNT_W + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          gate,
  input logic          out,
  input logic          out_q,
  input logic          armed,
  input logic [CW-1:0] cnt_q
);
  assert_gate_forces_high_R7: assert property (@(posedge clk) disable iff (rst)
    !gate |-> out);

  assert_idle_stays_high_R1: assert property (@(posedge clk) disable iff (rst)
    !armed |-> out);

  assert_fall_needs_gate_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(out_q) |-> $past(gate));

  assert_start_high_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> out_q);

  assert_cnt_even_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q[0] == 1'b0);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= {1'b1, {CNT_W{1'b0}}});
endmodule

bind sqw_gen sqw_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .gate(gate), .out(out), .out_q(out_q),
  .armed(armed), .cnt_q(cnt_q)
);

// File: tb/sqw_gen_tb.sv
module sqw_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gate = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_count = '0;
  logic        out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  sqw_gen u_dut (.clk(clk), .rst(rst), .gate(gate), .wr_en(wr_en),
                 .wr_count(wr_count), .out(out));

  always #4 clk = ~clk;  // 125 MHz

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; gate = 1'b1; wr_en = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic write_n(input int v);
    wr_en = 1'b1; wr_count = 16'(v);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wait_level(input logic v, output int n);
    n = 0;
    while (out !== v && n < 70000) begin
      tick();
      n++;
    end
  endtask

  task automatic t_reset_idle();
    int bad = 0;
    do_reset();
    for (int i = 0; i < 12; i++) begin
      if (out !== 1'b1) bad++;
      tick();
    end
    chk("R1 idle high cycles low", bad, 0);
  endtask

  task automatic t_widths(input int n, input string req);
    int ne, first, lo, hi;
    ne = (n == 0) ? 65536 : n;
    do_reset();
    write_n(n);
    wait_level(1'b0, first);
    chk({"R2 first fall ", req}, first, 1 + (ne + 1) / 2);
    wait_level(1'b1, lo);
    chk({req, " low width"}, lo, ne / 2);
    wait_level(1'b0, hi);
    chk({req, " high width"}, hi, (ne + 1) / 2);
  endtask

  task automatic t_illegal();
    int bad = 0, n, r, h;
    do_reset();
    write_n(1);
    for (int i = 0; i < 20; i++) begin
      if (out !== 1'b1) bad++;
      tick();
    end
    chk("R6 idle write of 1 started wave", bad, 0);
    write_n(6);
    wait_level(1'b0, n);
    write_n(1);
    wait_level(1'b1, r);
    chk("R6 low width after write of 1", r + 1, 3);
    wait_level(1'b0, h);
    chk("R6 high width after write of 1", h, 3);
  endtask

  task automatic t_deferred();
    int n, r, h, l;
    do_reset();
    write_n(4);
    wait_level(1'b0, n);
    write_n(8);
    wait_level(1'b1, r);
    chk("R9 current low half kept", r + 1, 2);
    wait_level(1'b0, h);
    chk("R9 new high half", h, 4);
    wait_level(1'b1, l);
    chk("R9 new low half", l, 4);
  endtask

  task automatic t_gate();
    int n, l, bad = 0;
    do_reset();
    write_n(6);
    wait_level(1'b0, n);
    gate = 1'b0;
    #1;
    chk("R7 out high without clock", int'(out), 1);
    for (int i = 0; i < 10; i++) begin
      tick();
      if (out !== 1'b1) bad++;
    end
    chk("R7 out high while gate low", bad, 0);
    gate = 1'b1;
    wait_level(1'b0, n);
    chk("R8 fall after trigger", n, 4);
    wait_level(1'b1, l);
    chk("R8 low width after trigger", l, 3);
  endtask

  task automatic t_trigger_new();
    int n, l, h;
    do_reset();
    write_n(8);
    wait_level(1'b0, n);
    write_n(4);
    gate = 1'b0;
    tick();
    gate = 1'b1;
    wait_level(1'b0, n);
    chk("R10 fall after trigger with new count", n, 3);
    wait_level(1'b1, l);
    chk("R10 low width", l, 2);
    wait_level(1'b0, h);
    chk("R10 high width", h, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset_idle();
    t_widths(2, "R3 N=2");
    t_widths(4, "R3 N=4");
    t_widths(10, "R3 N=10");
    t_widths(3, "R4 N=3");
    t_widths(5, "R4 N=5");
    t_widths(7, "R4 N=7");
    t_illegal();
    t_deferred();
    t_gate();
    t_trigger_new();
    t_widths(0, "R5 N=0");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule